// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Transmitter

This block turns a parallel byte into an asynchronous serial frame on a single line that rests high. A 3-bit format code selects one of four frame layouts:
- a plain 10-bit frame;
- an 11-bit frame with even parity;
- an 11-bit frame with odd parity;
- an 11-bit multidrop frame, in which a caller-supplied data-type bit takes the place of the parity bit.

The byte can be shifted out with either its least or its most significant bit first. The parity or type bit keeps its place next to the stop bit whatever the shift order.

Timing comes from an external bit-rate tick: every bit holds the line for exactly one tick interval. A byte enters through a valid/ready handshake. A send-break control replaces normal traffic with all-zero frames. A break request that is raised and then dropped yields one zero frame once the current frame is done. A break request that is held yields zero frames back to back. The line always returns high for at least one bit time before the next data frame begins.

Top module: `mfmt_serial_tx`

## Requirements
- R1: After reset the line is high. `tx_ready` is high only when the block is idle, the format code is valid, and no break is requested or pending. The line rests high whenever no frame is being sent.
- R2: A byte accepted on a clock edge where `tx_valid` and `tx_ready` are both high holds the line high until the next tick. That tick starts the start bit (0). Each later tick advances exactly one bit, and the line changes only on the clock edge where `bit_tick` is high.
- R3: Format code 3'b010 sends 10 bits: start 0, eight data bits, stop 1.
- R4: Format code 3'b100 sends 11 bits: start, eight data bits, a parity bit that makes the count of ones over data plus parity even, then stop 1.
- R5: Format code 3'b101 sends 11 bits with a parity bit that makes the count of ones over data plus parity odd. A byte with an even count of ones gets parity 1.
- R6: Format code 3'b110 sends 11 bits in which the bit before the stop bit is the `tx_type` value sampled at acceptance.
- R7: With `msb_first` = 1, data bit 7 goes out first; with 0, data bit 0 goes out first. The parity or type bit stays just before the stop bit in both orders.
- R8: A break request arriving during a data frame lets that frame finish. The block then sends one break frame of all zeros, 10 bits long for code 3'b010 and 11 bits long for the 11-bit codes. A request arriving while a break frame is in progress is merged into that frame.
- R9: While `send_brk` stays high, break frames follow one another with no high bit between them. The level at the end of each break frame decides whether another follows.
- R10: After the last break frame the line is high for at least one full bit time before any start bit.
- R11: Format codes 3'b000, 3'b001, 3'b011 and 3'b111 send nothing: `tx_ready` stays low, `tx_valid` is ignored, and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit interval |
| fmt_sel | input | 3 | Frame format code |
| msb_first | input | 1 | Data shift order, 1 = MSB first |
| send_brk | input | 1 | Break request level |
| tx_data | input | 8 | Byte to transmit |
| tx_type | input | 1 | Data-type bit for multidrop frames |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be taken this cycle |
| tx_line | output | 1 | Serial output, high at rest |

## Verification
Internal state corruption shows on `tx_line` within one tick interval, because every bit position is driven straight from the bit counter and the frame register.

Typical faults and how they appear:
- A wrong counter limit stretches or clips a frame. The next expected start or idle bit then turns up as a mismatch.
- A misordered frame register flips a data bit at its own slot in the frame.
- A lost break-pending flag lets `tx_ready` rise early and breaks the zero run.

A scoreboard holds every expected bit, including the idle high between frames. The first wrong sample after a tick is therefore caught, and so is any movement of the line between ticks.

// File: rtl/mfmt_serial_tx.sv
module mfmt_serial_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [2:0]        fmt_sel,
  input  logic              msb_first,
  input  logic              send_brk,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_type,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_line
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [FW-1:0]    fr, nf;
  logic             len11, isbrk, brk_req;

  wire fmt_ok  = (fmt_sel == 3'b010) || (fmt_sel == 3'b100) ||
                 (fmt_sel == 3'b101) || (fmt_sel == 3'b110);
  wire [CW-1:0] last_idx = len11 ? CW'(FW-1) : CW'(FW-2);
  wire accept  = tx_valid && tx_ready;
  wire in_brk  = (st == S_SEND) && isbrk;
  wire brk_go  = fmt_ok && (brk_req || (isbrk && send_brk));

  assign tx_ready = (st == S_IDLE) && fmt_ok && !send_brk && !brk_req;
  assign tx_line  = (st == S_SEND) ? (!isbrk && fr[cnt]) : 1'b1;

  always_comb begin
    nf    = '1;
    nf[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      nf[1+i] = msb_first ? tx_data[DATA_W-1-i] : tx_data[i];
    if (fmt_sel[2])
      nf[DATA_W+1] = (fmt_sel == 3'b110) ? tx_type
                   : (fmt_sel[0] ? ~^tx_data : ^tx_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      fr      <= '1;
      len11   <= 1'b0;
      isbrk   <= 1'b0;
      brk_req <= 1'b0;
    end else begin
      if (send_brk && !in_brk) brk_req <= 1'b1;
      case (st)
        S_IDLE: begin
          if (accept) begin
            fr    <= nf;
            len11 <= fmt_sel[2];
            st    <= S_WAIT;
          end else if (bit_tick && brk_req && fmt_ok) begin
            st      <= S_SEND;
            cnt     <= '0;
            isbrk   <= 1'b1;
            len11   <= fmt_sel[2];
            brk_req <= 1'b0;
          end
        end
        S_WAIT: begin
          if (bit_tick) begin
            st    <= S_SEND;
            cnt   <= '0;
            isbrk <= 1'b0;
          end
        end
        S_SEND: begin
          if (bit_tick) begin
            if (cnt == last_idx) begin
              if (brk_go) begin
                cnt     <= '0;
                isbrk   <= 1'b1;
                len11   <= fmt_sel[2];
                brk_req <= 1'b0;
              end else begin
                st    <= S_IDLE;
                isbrk <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mfmt_serial_tx_chk.sv
module mfmt_serial_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic [2:0] fmt_sel,
  input logic       send_brk,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_line
);
  wire code_ok = (fmt_sel == 3'b010) || (fmt_sel == 3'b100) ||
                 (fmt_sel == 3'b101) || (fmt_sel == 3'b110);

  a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_line));

  a_r11_no_ready_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |-> !tx_ready);

  a_r1_no_ready_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    send_brk |-> !tx_ready);

  a_r1_one_take_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r2_high_until_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> tx_line);
endmodule

bind mfmt_serial_tx mfmt_serial_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fmt_sel(fmt_sel),
  .send_brk(send_brk), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_line(tx_line)
);

// File: tb/mfmt_serial_tx_test.sv
module mfmt_serial_tx_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [2:0] fmt_sel = 3'b010;
  logic       msb_first = 1'b0;
  logic       send_brk = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_type = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_line;

  mfmt_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fmt_sel(fmt_sel),
    .msb_first(msb_first), .send_brk(send_brk), .tx_data(tx_data),
    .tx_type(tx_type), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_line(tx_line)
  );

  typedef struct { logic b; string tag; } exp_t;
  exp_t exp_q[$];

  int  n_run = 0, n_fail = 0;
  logic last_tick = 1'b0;
  logic prev_line = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  always @(posedge clk) last_tick <= bit_tick;

  task automatic check(input logic ok, input string tag, input logic act, input logic exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic b, input string tag);
    exp_t e;
    e.b = b;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (last_tick) begin
          if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(tx_line === e.b, e.tag, tx_line, e.b);
          end else begin
            check(tx_line === 1'b1, "R1 idle", tx_line, 1'b1);
          end
        end else begin
          check(tx_line === prev_line, "R2 between ticks", tx_line, prev_line);
        end
        prev_line = tx_line;
      end
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!bit_tick) @(posedge clk);
    end
    @(negedge clk);
    #1;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    wait_ticks(2);
  endtask

  task automatic send(input logic [7:0] d, input logic [2:0] ws, input logic msb,
                      input logic dt, input string tag);
    logic acc_tick;
    fmt_sel   = ws;
    msb_first = msb;
    tx_data   = d;
    tx_type   = dt;
    tx_valid  = 1'b1;
    #1;
    while (!tx_ready) begin
      @(negedge clk);
      #1;
    end
    acc_tick = bit_tick;
    @(posedge clk);
    if (acc_tick) push(1'b1, "R2 wait");
    push(1'b0, {tag, " start"});
    for (int i = 0; i < 8; i++) push(msb ? d[7-i] : d[i], {tag, " data"});
    if (ws == 3'b100) push(^d, "R4 even parity slot");
    if (ws == 3'b101) push(~^d, "R5 odd parity slot");
    if (ws == 3'b110) push(dt, "R6 type slot");
    push(1'b1, {tag, " stop"});
    @(negedge clk);
    #1;
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_line === 1'b1, "R1 reset line", tx_line, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(tx_ready === 1'b1, "R1 ready after reset", tx_ready, 1'b1);

    send(8'hA5, 3'b010, 1'b0, 1'b0, "R3");
    send(8'h3C, 3'b010, 1'b1, 1'b0, "R7 msb R3");
    send(8'h07, 3'b100, 1'b0, 1'b0, "R4");
    send(8'h03, 3'b100, 1'b0, 1'b0, "R4");
    send(8'hF0, 3'b100, 1'b1, 1'b0, "R7 msb R4");
    send(8'h07, 3'b101, 1'b0, 1'b0, "R5");
    send(8'h00, 3'b101, 1'b0, 1'b0, "R5");
    send(8'h81, 3'b110, 1'b0, 1'b1, "R6");
    send(8'h12, 3'b110, 1'b1, 1'b0, "R7 msb R6");
    drain();

    // R8: break pulse during a 10-bit frame
    send(8'h5A, 3'b010, 1'b0, 1'b0, "R8 pre");
    send_brk = 1'b1;
    #1;
    check(tx_ready === 1'b0, "R1 ready low with break", tx_ready, 1'b0);
    for (int i = 0; i < 10; i++) push(1'b0, "R8 break bit");
    push(1'b1, "R10 mark");
    wait_ticks(2);
    send_brk = 1'b0;
    send(8'hC3, 3'b010, 1'b0, 1'b0, "R10 next");
    drain();

    // R9: held break in 11-bit format, three frames
    fmt_sel = 3'b101;
    wait_ticks(1);
    send_brk = 1'b1;
    #1;
    check(tx_ready === 1'b0, "R1 ready low with break idle", tx_ready, 1'b0);
    for (int i = 0; i < 33; i++) push(1'b0, "R9 held break bit");
    push(1'b1, "R10 mark");
    wait_ticks(29);
    send_brk = 1'b0;
    send(8'h96, 3'b101, 1'b1, 1'b0, "R10 next");
    drain();

    // R11: unused codes
    for (int k = 0; k < 4; k++) begin
      fmt_sel  = (k == 0) ? 3'b000 : (k == 1) ? 3'b001 : (k == 2) ? 3'b011 : 3'b111;
      tx_data  = 8'h00;
      tx_valid = 1'b1;
      repeat (12) begin
        @(negedge clk);
        #1;
        check(tx_ready === 1'b0, "R11 ready low", tx_ready, 1'b0);
      end
      tx_valid = 1'b0;
    end
    wait_ticks(3);
    send(8'h69, 3'b010, 1'b0, 1'b0, "R11 recover R3");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule